// File: doc/BRIEF.md
# Three-Operand Floating-Point Multiplier

This block multiplies three operands of a compact floating-point format and returns one product in the same format. Each operand is a 17-bit word made of a sign, a 6-bit biased exponent and a 10-bit fraction with an implied leading one. A single request starts the operation. The block first pre-normalizes all three operands. It then runs one shared carry-save array multiplier twice: first on A times B, then on that truncated partial product times C. One shared exponent adder and one shared normalizer serve both passes.

Neither pass rounds. After each multiply the block keeps the top 11 bits of the normalized significand and drops the rest. The final exponent is then checked against the format limits. Too large a value saturates to the largest magnitude. Too small a value flushes to zero. A zero operand forces an exact zero. The result stays on the output until the next operation completes, and a one-cycle completion pulse marks each new result.

Top module: `fmul3`

## Requirements
- R1: An operand word holds the sign in bit 16, the exponent in bits 15:10 with bias 31 and the fraction in bits 9:0. When the exponent is nonzero, the value is (1 + fraction/1024) * 2^(exponent-31).
- R2: A start seen on a rising edge while the block is idle begins an operation. `done` is high for exactly the one cycle that follows the third rising edge, counting the edge that sampled start. `result` is valid in that cycle and holds its value until the next operation completes.
- R3: A start asserted while an operation is in progress is ignored. The running operation completes with its own operands, and no extra completion follows.
- R4: The sign of a nonzero result is the XOR of the three operand signs.
- R5: The product is computed as (A*B)*C on 11-bit significands. After each multiply, a 22-bit product with bit 21 set keeps bits 21:11 and adds one to the exponent. Otherwise it keeps bits 20:10. The result exponent is the sum of the three exponents minus 62, plus those carries.
- R6: An operand with exponent 0 and a nonzero fraction is read as (fraction/1024) * 2^-30. It is shifted left until its leading one is in the hidden position, and its exponent is lowered by one for each shift.
- R7: If any operand has exponent 0 and fraction 0, the result is all zeros (17'h00000), whatever the signs.
- R8: If the final exponent exceeds 63, the result keeps its sign and has exponent 63 and fraction 10'h3FF.
- R9: If the final exponent is below 1, the result is all zeros. The block never outputs a word with exponent 0 and a nonzero fraction.
- R10: While reset is held low and after its release, `done` is 0 and `result` is 17'h00000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation on the current operands |
| opA | input | 17 | First operand |
| opB | input | 17 | Second operand |
| opC | input | 17 | Third operand |
| done | output | 1 | One-cycle pulse when a new result is on `result` |
| result | output | 17 | Product of the last completed operation |

## Verification
The hardest cases to reach from the ports are those where the carry out of the first multiply decides the outcome at a format edge. An exponent can land exactly on 63 or exactly on 1, or sit one beyond either limit. A denormal operand can drive an intermediate exponent to zero or below before the third operand brings it back into range. The stimulus builds operands by hand so that the exponent sum sits on each side of both limits. It pairs a denormal with a large third operand, and it uses 1.5-style fractions, whose first product carries, to shift the final exponent by one. A seeded sweep over full 17-bit words is then compared with a bench model written from the rules above.

// File: rtl/fmul3_pkg.sv
package fmul3_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic ld;    // capture pre-normalized operands
    logic mul1;  // first pass: A * B
    logic mul2;  // second pass: (A*B) * C, write result
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL1 = 2'd1,
    ST_MUL2 = 2'd2
  } state_t;

endpackage

// File: rtl/fmul3_csa.sv
// Unsigned N x N array multiplier: rows of 3:2 compressors keep sum and
// carry vectors apart; one carry-propagate add at the bottom.
module fmul3_csa #(
  parameter int N = 11
) (
  input  logic [N-1:0]   x,
  input  logic [N-1:0]   y,
  output logic [2*N-1:0] p
);
  localparam int W = 2 * N;

  for (genvar r = 0; r < N; r++) begin : row
    logic [W-1:0] sIn, cIn, pp, sOut, cOut;
    if (r == 0) begin : first
      assign sIn = '0;
      assign cIn = '0;
    end else begin : chain
      assign sIn = row[r-1].sOut;
      assign cIn = row[r-1].cOut;
    end
    assign pp   = {{N{1'b0}}, x & {N{y[r]}}} << r;
    assign sOut = sIn ^ cIn ^ pp;
    assign cOut = ((sIn & cIn) | (sIn & pp) | (cIn & pp)) << 1;
  end

  assign p = row[N-1].sOut + row[N-1].cOut;
endmodule

// File: rtl/fmul3_prenorm.sv
// Moves the leading one of an operand's significand to the hidden position.
module fmul3_prenorm #(
  parameter int EXP_W = 6,
  parameter int MAN_W = 10,
  parameter int XW    = EXP_W + 4
) (
  input  logic [EXP_W-1:0]    expIn,
  input  logic [MAN_W-1:0]    manIn,
  output logic [MAN_W:0]      sigOut,
  output logic signed [XW-1:0] expOut,
  output logic                zeroOut
);
  localparam int SIG_W = MAN_W + 1;
  localparam int LZ_W  = $clog2(SIG_W + 1);

  logic [SIG_W-1:0] raw;
  logic [LZ_W-1:0]  lz;
  logic             found;
  logic signed [XW-1:0] expBase;

  always_comb begin
    raw   = {|expIn, manIn};
    lz    = '0;
    found = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (raw[i]) found = 1'b1;
        else        lz    = lz + 1'b1;
      end
    end
    expBase = (expIn == '0) ? XW'(1) : XW'(expIn);
    sigOut  = raw << lz;
    expOut  = expBase - $signed(XW'(lz));
    zeroOut = (expIn == '0) && (manIn == '0);
  end
endmodule

// File: rtl/fmul3_ctrl.sv
module fmul3_ctrl
  import fmul3_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t stb,
  output logic    doneQ
);
  state_t stateQ, stateD;

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (start) begin stb.ld = 1'b1; stateD = ST_MUL1; end
      ST_MUL1: begin stb.mul1 = 1'b1; stateD = ST_MUL2; end
      ST_MUL2: begin stb.mul2 = 1'b1; stateD = ST_IDLE; end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= stb.mul2;
    end
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ld, stb.mul1, stb.mul2}));
  // R2
  seq_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld |=> stb.mul1 ##1 stb.mul2 ##1 doneQ);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R3
  no_reaccept_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld |=> !stb.ld);
endmodule

// File: rtl/fmul3_dpath.sv
module fmul3_dpath
  import fmul3_pkg::*;
#(
  parameter int EXP_W = 6,
  parameter int MAN_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [EXP_W+MAN_W:0]     opA,
  input  logic [EXP_W+MAN_W:0]     opB,
  input  logic [EXP_W+MAN_W:0]     opC,
  output logic [EXP_W+MAN_W:0]     resultQ
);
  localparam int SIG_W   = MAN_W + 1;
  localparam int WORD_W  = 1 + EXP_W + MAN_W;
  localparam int XW      = EXP_W + 4;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam logic signed [XW-1:0] BIAS_X = XW'(BIAS);
  localparam logic signed [XW-1:0] ONE_X  = XW'(1);
  localparam logic signed [XW-1:0] ZERO_X = XW'(0);
  localparam logic signed [XW-1:0] MAX_X  = XW'(EXP_MAX);

  logic [WORD_W-1:0]    opV   [3];
  logic [SIG_W-1:0]     pnSig [3];
  logic signed [XW-1:0] pnExp [3];
  logic                 pnZero[3];

  logic [SIG_W-1:0]     sigQ [3];
  logic signed [XW-1:0] expQ [3];
  logic [2:0]           sgnQ;
  logic                 zeroQ;
  logic [SIG_W-1:0]     sigAbQ;
  logic signed [XW-1:0] expAbQ;

  assign opV[0] = opA;
  assign opV[1] = opB;
  assign opV[2] = opC;

  for (genvar g = 0; g < 3; g++) begin : pn
    fmul3_prenorm #(.EXP_W(EXP_W), .MAN_W(MAN_W), .XW(XW)) u_pn (
      .expIn  (opV[g][WORD_W-2:MAN_W]),
      .manIn  (opV[g][MAN_W-1:0]),
      .sigOut (pnSig[g]),
      .expOut (pnExp[g]),
      .zeroOut(pnZero[g])
    );
  end

  // One multiplier, one exponent adder, one normalizer for both passes
  logic [SIG_W-1:0]     mulX, mulY, normSig;
  logic [2*SIG_W-1:0]   prod;
  logic                 prodHi;
  logic signed [XW-1:0] expL, expR, expSum;

  assign mulX = stb.mul2 ? sigAbQ : sigQ[0];
  assign mulY = stb.mul2 ? sigQ[2] : sigQ[1];
  assign expL = stb.mul2 ? expAbQ : expQ[0];
  assign expR = stb.mul2 ? expQ[2] : expQ[1];

  fmul3_csa #(.N(SIG_W)) u_mul (.x(mulX), .y(mulY), .p(prod));

  assign prodHi  = prod[2*SIG_W-1];
  assign normSig = prodHi ? SIG_W'(prod >> SIG_W) : SIG_W'(prod >> (SIG_W - 1));
  assign expSum  = expL + expR - BIAS_X + (prodHi ? ONE_X : ZERO_X);

  logic [WORD_W-1:0] packed_;
  logic              sgnR;
  assign sgnR = ^sgnQ;

  always_comb begin
    if (zeroQ || expSum < ONE_X)  packed_ = '0;
    else if (expSum > MAX_X)      packed_ = {sgnR, {EXP_W{1'b1}}, {MAN_W{1'b1}}};
    else                          packed_ = {sgnR, EXP_W'(expSum), MAN_W'(normSig)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin
        sigQ[i] <= '0;
        expQ[i] <= '0;
      end
      sgnQ    <= '0;
      zeroQ   <= 1'b0;
      sigAbQ  <= '0;
      expAbQ  <= '0;
      resultQ <= '0;
    end else begin
      if (stb.ld) begin
        for (int i = 0; i < 3; i++) begin
          sigQ[i] <= pnSig[i];
          expQ[i] <= pnExp[i];
          sgnQ[i] <= opV[i][WORD_W-1];
        end
        zeroQ <= pnZero[0] | pnZero[1] | pnZero[2];
      end
      if (stb.mul1) begin
        sigAbQ <= normSig;
        expAbQ <= expSum;
      end
      if (stb.mul2) resultQ <= packed_;
    end
  end

  // R9
  no_denorm_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultQ[WORD_W-2:MAN_W] == '0) |-> (resultQ == '0));
  // R7
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mul2 && zeroQ) |=> (resultQ == '0));
  // R4
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.mul2 |=> (resultQ == '0) || (resultQ[WORD_W-1] == ^$past(sgnQ)));
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.mul2 |=> $stable(resultQ));
  // R5
  norm_hidden_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mul1 && !zeroQ) |=> sigAbQ[SIG_W-1]);
endmodule

// File: rtl/fmul3.sv
module fmul3
  import fmul3_pkg::*;
#(
  parameter  int EXP_W  = 6,
  parameter  int MAN_W  = 10,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] opC,
  output logic              done,
  output logic [WORD_W-1:0] result
);
  strobe_t stb;

  fmul3_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stb  (stb),
    .doneQ(done)
  );

  fmul3_dpath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .opA    (opA),
    .opB    (opB),
    .opC    (opC),
    .resultQ(result)
  );
endmodule

// File: tb/sim_fmul3.sv
module sim_fmul3;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [16:0] opA = '0, opB = '0, opC = '0;
  logic        done;
  logic [16:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  fmul3 u0 (.clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
            .opC(opC), .done(done), .result(result));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model built from the requirements
  function automatic logic [16:0] model(input logic [16:0] a, b, c);
    logic [16:0] v[3];
    int s[3], e[3], p, sab, eab, sr, er;
    bit z, sg;
    v[0] = a; v[1] = b; v[2] = c;
    z = 0; sg = a[16] ^ b[16] ^ c[16];
    for (int i = 0; i < 3; i++) begin
      if (v[i][15:10] == 0 && v[i][9:0] == 0) z = 1;
      s[i] = (v[i][15:10] != 0) ? 1024 + int'(v[i][9:0]) : int'(v[i][9:0]);
      e[i] = (v[i][15:10] != 0) ? int'(v[i][15:10]) : 1;
      while (s[i] != 0 && s[i] < 1024) begin s[i] = s[i] * 2; e[i] = e[i] - 1; end
    end
    if (z) return 17'h0;
    p = s[0] * s[1];
    if (p >= 2097152) begin sab = p / 2048; eab = e[0] + e[1] - 31 + 1; end
    else              begin sab = p / 1024; eab = e[0] + e[1] - 31; end
    p = sab * s[2];
    if (p >= 2097152) begin sr = p / 2048; er = eab + e[2] - 31 + 1; end
    else              begin sr = p / 1024; er = eab + e[2] - 31; end
    if (er < 1) return 17'h0;
    if (er > 63) return {sg, 6'h3F, 10'h3FF};
    return {sg, 6'(er), 10'(sr)};
  endfunction

  function automatic logic [16:0] mk(input bit s, input int e, input int f);
    return {s, 6'(e), 10'(f)};
  endfunction

  // Runs one operation; returns cycles until done (99 on timeout)
  task automatic runOp(input logic [16:0] a, b, c, output int lat);
    @(negedge clk);
    opA = a; opB = b; opC = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    if (!done) lat = 99;
  endtask

  task automatic opCheck(input string req, input logic [16:0] a, b, c, input logic [16:0] exp);
    int lat;
    runOp(a, b, c, lat);
    check({req, " latency(R2)"}, lat, 3);
    check(req, result, exp);
  endtask

  task automatic tReset();
    check("R10 done in reset", done, 0);
    check("R10 result in reset", result, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R10 done after reset", done, 0);
    check("R10 result after reset", result, 0);
  endtask

  task automatic tUnit();
    opCheck("R1 1*1*1", 17'h07C00, 17'h07C00, 17'h07C00, 17'h07C00);
    opCheck("R5 1.5^3", mk(0,31,512), mk(0,31,512), mk(0,31,512), 17'h082C0);
  endtask

  task automatic tHold();
    logic [16:0] keep;
    int lat;
    runOp(mk(0,33,100), mk(0,29,700), mk(0,31,5), lat);
    keep = result;
    check("R2 value", result, model(mk(0,33,100), mk(0,29,700), mk(0,31,5)));
    @(negedge clk);
    check("R2 done one cycle", done, 0);
    opA = '1; opB = '1; opC = '1;
    repeat (3) @(negedge clk);
    check("R2 result held", result, keep);
  endtask

  task automatic tSigns();
    for (int k = 0; k < 8; k++) begin
      logic [16:0] a, b, c;
      a = mk(k[0], 30, 300); b = mk(k[1], 32, 17); c = mk(k[2], 31, 1000);
      opCheck("R4 sign", a, b, c, model(a, b, c));
      check("R4 sign bit", result[16], k[0] ^ k[1] ^ k[2]);
    end
  endtask

  task automatic tSweep();
    logic [31:0] seed = 32'h1234_5678;
    for (int k = 0; k < 40; k++) begin
      logic [16:0] a, b, c;
      seed = seed * 32'd1664525 + 32'd1013904223; a = seed[30:14];
      seed = seed * 32'd1664525 + 32'd1013904223; b = seed[30:14];
      seed = seed * 32'd1664525 + 32'd1013904223; c = seed[30:14];
      if (k < 20) begin a[15:10] = 6'(24 + k % 14); b[15:10] = 6'(28 + k % 7); c[15:10] = 6'(30 + k % 5); end
      opCheck("R5 sweep", a, b, c, model(a, b, c));
    end
  endtask

  task automatic tDenorm();
    opCheck("R6 denorm half", mk(0,0,512), 17'h07C00, mk(0,61,0), 17'h07800);
    opCheck("R6 denorm small", mk(1,0,3), mk(0,50,77), mk(0,62,900),
            model(mk(1,0,3), mk(0,50,77), mk(0,62,900)));
  endtask

  task automatic tZero();
    opCheck("R7 zero B", mk(1,60,1023), 17'h0, mk(0,40,5), 17'h0);
    opCheck("R7 neg zero C", mk(0,31,0), mk(1,31,0), mk(1,0,0), 17'h0);
  endtask

  task automatic tOverflow();
    opCheck("R8 max exp exact", mk(0,63,0), mk(0,31,0), mk(0,31,0), 17'h0FC00);
    opCheck("R8 exp 64", mk(0,63,0), mk(0,32,0), mk(0,31,0), 17'h0FFFF);
    opCheck("R8 all max neg", mk(1,63,0), mk(0,63,0), mk(0,63,0), 17'h1FFFF);
  endtask

  task automatic tUnderflow();
    opCheck("R9 exp 1 exact", mk(0,1,0), mk(0,31,0), mk(0,31,0), 17'h00400);
    opCheck("R9 exp 0 flush", mk(1,1,0), mk(0,30,0), mk(0,31,0), 17'h0);
    opCheck("R9 carry lifts", mk(0,1,512), mk(0,30,512), mk(0,31,512), 17'h006C0);
  endtask

  task automatic tBusy();
    logic [16:0] a, b, c;
    int lat;
    a = mk(0,31,256); b = mk(1,32,64); c = mk(0,30,900);
    @(negedge clk);
    opA = a; opB = b; opC = c; start = 1'b1;
    @(negedge clk);
    opA = mk(0,40,1); opB = mk(0,40,2); opC = mk(0,40,3);
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    check("R3 first op latency", lat, 3);
    check("R3 first op result", result, model(a, b, c));
    repeat (4) begin
      @(negedge clk);
      check("R3 no extra done", done, 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    tReset();
    tUnit();
    tHold();
    tSigns();
    tSweep();
    tDenorm();
    tZero();
    tOverflow();
    tUnderflow();
    tBusy();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule